// File: doc/BRIEF.md
# Pulse-Width Bit Decoder

This block recovers a serial bit stream in which every bit occupies one frame of fixed length, and each frame opens with a rising edge of the line. A long high pulse inside the frame encodes a one, and a short high pulse encodes a zero. The line is asynchronous to the block's clock. It first passes through a flop synchronizer. Each synchronized rising edge restarts an 8-bit free-running counter that advances once per clock.

When the counter reaches a programmable threshold for the first time in a frame, the block samples the line level on the next edge. That level is the decoded bit. It is held on the output and announced by a single-cycle strobe. The decision therefore rests on the live line level at one instant, not on a stored pulse length.

The arming logic is a three-state machine:
- `ST_IDLE` is the state after reset. No frame has opened yet.
- `ST_ARMED` means a frame has opened and no sample has been taken.
- `ST_DONE` means the frame's bit has been taken.

Its transitions are:
- idle-to-armed, done-to-armed and armed-to-armed (restart) all happen on a rising edge.
- armed-to-done happens on the threshold match. It is taken only when no rising edge arrives in the same cycle.

Software loads the threshold through a one-cycle write port. The value is copied into the active compare register at every frame start.

Top module: `pw_bit_decoder`

## Requirements
- R1: After reset, `bit_out` is 0, `bit_valid` is 0 and the threshold is 0xFF. No strobe appears while the line has shown no rising edge.
- R2: Let the line go high before clock edge P. With active threshold T, `bit_valid` is high for exactly the cycle after edge P+T+3. The clear happens at edge P+2, and the sample is taken T+1 periods after it.
- R3: The decoded bit equals the line level sampled at edge P+T+1. A high pulse lasting H clock cycles from edge P therefore decodes as 1 exactly when H >= T+2, and as 0 otherwise.
- R4: The 8-bit counter wraps from 0xFF to 0x00 without stopping. A wrap past the threshold within the same frame never produces a second strobe, so no strobe appears until the next rising edge.
- R5: A threshold write (`thr_we` high for one cycle with `thr_wdata`) takes effect from the next frame. A frame already running keeps the value copied at its start.
- R6: `bit_valid` is never high for two cycles in a row. `bit_out` changes only in a cycle where `bit_valid` is high.
- R7: A rising edge that arrives before the match restarts the frame. The aborted frame yields no strobe.
- R8: With threshold 0, the decision falls one period after the clear, so the strobe appears after edge P+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock; the counter advances on every edge |
| rst_n | input | 1 | active-low synchronous reset |
| pulse_in | input | 1 | asynchronous pulse-coded line |
| thr_we | input | 1 | threshold write enable |
| thr_wdata | input | 8 | threshold write data |
| bit_out | output | 1 | last decoded bit, held between strobes |
| bit_valid | output | 1 | one-cycle strobe marking a fresh decoded bit |

## Verification
The hardest situation to reach from the ports is a threshold write that lands in the middle of a running frame. The check must show that the sample instant still follows the value copied at the frame start. The bench handles this by issuing a write at a chosen cycle inside a frame. It then measures the strobe position in that frame and in the frame that follows, and the two positions differ. Counter wrap without a fresh edge is reached by holding the line low for more than two full counter periods after a decoded frame.

// File: rtl/pwd_pkg.sv
`timescale 1ns/1ps
package pwd_pkg;
    // arming state of the per-frame sampler
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DONE  = 2'd2
    } arm_state_t;
endpackage

// File: rtl/pwd_sync.sv
`timescale 1ns/1ps
module pwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;

    // R2
    rise_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("rise detected on consecutive cycles");
endmodule

// File: rtl/pwd_frame_ctr.sv
`timescale 1ns/1ps
module pwd_frame_ctr #(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] THR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] thr_reg;
    logic [CNT_W-1:0] thr_act;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (rise)   cnt <= '0;
        else             cnt <= cnt + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      thr_reg <= THR_RST;
        else if (thr_we) thr_reg <= thr_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      thr_act <= THR_RST;
        else if (rise)   thr_act <= thr_reg;
    end

    assign match = (cnt == thr_act);

    // R4
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> cnt == $past(cnt) + ONE)
        else $error("counter failed to advance");
    // R2
    ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> cnt == '0)
        else $error("counter not cleared on frame start");
    // R5
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(thr_act))
        else $error("active threshold moved mid-frame");
endmodule

// File: rtl/pwd_arm_fsm.sv
`timescale 1ns/1ps
module pwd_arm_fsm
    import pwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic match,
    input  logic lvl,
    output logic bit_out,
    output logic bit_valid
);
    arm_state_t state, state_nx;
    logic       take;

    assign take = (state == ST_ARMED) && match && !rise;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (rise) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (rise)       state_nx = ST_ARMED;
                else if (match) state_nx = ST_DONE;
            end
            ST_DONE:  if (rise) state_nx = ST_ARMED;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= take;
            if (take) bit_out <= lvl;
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid)
        else $error("strobe longer than one cycle");
    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out) || $past(!rst_n))
        else $error("decoded bit moved without strobe");
    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !rise) |=> !bit_valid)
        else $error("second sample within one frame");
endmodule

// File: rtl/pw_bit_decoder.sv
`timescale 1ns/1ps
module pw_bit_decoder #(
    parameter int          CNT_W       = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] THR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    output logic             bit_out,
    output logic             bit_valid
);
    logic             lvl;
    logic             rise;
    logic             match;
    logic [CNT_W-1:0] cnt;

    pwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .lvl      (lvl),
        .rise     (rise)
    );

    pwd_frame_ctr #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .cnt       (cnt),
        .match     (match)
    );

    pwd_arm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .match     (match),
        .lvl       (lvl),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    // R3
    sample_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> bit_out == $past(lvl))
        else $error("decoded bit differs from line level");
endmodule

// File: tb/tb_pw_bit_decoder.sv
`timescale 1ns/1ps
module tb_pw_bit_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_in = 1'b0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wdata = 8'h00;
    logic       bit_out;
    logic       bit_valid;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pw_bit_decoder dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    // {threshold, high cycles, frame cycles, expected bit}
    localparam logic [24:0] VEC [10] = '{
        {8'd10,  8'd30,  8'd40,  1'b1},
        {8'd10,  8'd5,   8'd40,  1'b0},
        {8'd10,  8'd12,  8'd40,  1'b1},
        {8'd10,  8'd11,  8'd40,  1'b0},
        {8'd0,   8'd1,   8'd10,  1'b0},
        {8'd0,   8'd2,   8'd10,  1'b1},
        {8'd50,  8'd60,  8'd80,  1'b1},
        {8'd50,  8'd40,  8'd80,  1'b0},
        {8'd200, 8'd210, 8'd220, 1'b1},
        {8'd200, 8'd100, 8'd220, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_thr(input logic [7:0] v);
        @(negedge clk);
        thr_we = 1'b1;
        thr_wdata = v;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    // one frame: line rises before edge P, stays high hi cycles, frame lasts len cycles
    task automatic run_frame(input int hi, input int len, input int exp_at,
                             input bit exp_bit, input int wr_at, input logic [7:0] wr_val,
                             input string req);
        int strobes = 0;
        int stray = 0;
        @(negedge clk);
        pulse_in = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == hi - 1) pulse_in = 1'b0;
            thr_we = (i == wr_at);
            thr_wdata = wr_val;
            if (bit_valid) strobes++;
            if (i == exp_at) begin
                check(bit_valid == 1'b1, {req, " strobe timing R2"}, int'(bit_valid), 1);
                check(bit_out == exp_bit, {req, " decoded bit R3"}, int'(bit_out), int'(exp_bit));
            end else if (bit_valid) begin
                stray++;
            end
        end
        thr_we = 1'b0;
        check(stray == 0, {req, " stray strobes R6 R7"}, stray, 0);
        if (exp_at < 0)
            check(strobes == 0, {req, " aborted frame R7"}, strobes, 0);
    endtask

    initial begin
        int cnt_v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bit_out == 1'b0, "R1 bit_out at reset", int'(bit_out), 0);
        check(bit_valid == 1'b0, "R1 bit_valid at reset", int'(bit_valid), 0);
        rst_n = 1'b1;
        cnt_v = 0;
        repeat (300) begin
            @(negedge clk);
            if (bit_valid) cnt_v++;
        end
        check(cnt_v == 0, "R1 no strobe before first edge", cnt_v, 0);
        // R1 default threshold 0xFF: strobe at 255+3, H=258 gives 1
        run_frame(258, 270, 258, 1'b1, -1, 8'h00, "R1 default threshold");

        // vector table
        for (int k = 0; k < 10; k++) begin
            logic [7:0] t, h, f;
            logic       e;
            {t, h, f, e} = VEC[k];
            write_thr(t);
            run_frame(int'(h), int'(f), int'(t) + 3, e, -1, 8'h00,
                      (t == 8'd0) ? "R8 zero threshold" : "R3 table");
        end

        // R5 mid-frame write: frame uses 6, next frame uses 15
        write_thr(8'd6);
        run_frame(20, 30, 9, 1'b1, 2, 8'd15, "R5 write mid-frame");
        run_frame(16, 40, 18, 1'b0, -1, 8'h00, "R5 next frame");

        // R7 restart before match
        run_frame(5, 10, -1, 1'b0, -1, 8'h00, "R7 short frame");
        run_frame(30, 40, 18, 1'b1, -1, 8'h00, "R7 after restart");

        // R4 wrap without new edge
        cnt_v = 0;
        repeat (600) begin
            @(negedge clk);
            if (bit_valid) cnt_v++;
        end
        check(cnt_v == 0, "R4 no strobe across wraps", cnt_v, 0);
        check(bit_out == 1'b1, "R6 bit held across idle", int'(bit_out), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule